// File: doc/BRIEF.md
# Dual-Bank-Operation Flash Command Sequencer

A behavioural controller for a NOR flash array split into banks. The host issues bus writes; the controller decodes multi-write command sequences and runs program and sector-erase jobs as internal timed operations of a fixed cycle count. While a job occupies one bank, reads aimed at any other bank return stored data with the normal one-cycle latency. The bank in use answers reads with a status word instead of data.

The host tracks a job in two ways. It can watch the ready output, or it can poll the busy bank and read the status bits: an inverted bit 7, a bit 6 that flips on every status read, and a bit 2 that flips only while an erase is in progress. A running erase can be suspended. During the suspension, other sectors can be read or programmed, and a resume command finishes the erase. An unlock-bypass mode shortens each program to two writes. The storage is a small register model. A program can only clear bits, and an erase sets a whole sector to ones.

Top module: `flash_dual_op_seq`

## Requirements
- R1: While rst_ni is low, and after it is released, ready_o is 1, rd_data_o is 0 and bypass mode is off. A reset during a job aborts it and leaves the target word unchanged.
- R2: Writes 0xAA@0x15, 0x55@0x0A, 0xA0@0x15 followed by (addr,data) start a program. ready_o is 0 for exactly PROG_CYCLES cycles after the clock edge that takes the last write.
- R3: A completed program stores old_word AND data. Bits can only go from 1 to 0.
- R4: Writes 0xAA@0x15, 0x55@0x0A, 0x80@0x15, 0xAA@0x15, 0x55@0x0A, 0x30@sector start an erase of the sector addressed by the last write. ready_o is 0 for ERASE_CYCLES cycles, and then every word of that sector reads 0xFF while other sectors are unchanged. The address is {bank[4:3], sector[2], word[1:0]}.
- R5: A read (rd_en_i) of a bank that is not busy returns stored data on rd_data_o one cycle later, even while a job runs in another bank.
- R6: A read of the busy bank returns a status word. Bit 7 is the inverse of bit 7 of the program data, or 0 during an erase. All bits other than 7, 6 and 2 are 0.
- R7: In status words, bit 6 is 0 on the first read after a job starts and flips on each following status read. Bit 2 equals bit 6 during an erase and is 0 during a program.
- R8: When a job ends, the controller returns to array reads by itself, and reads of that bank return data.
- R9: Writing 0xB0 during a running erase suspends it. ready_o is 1 from the next cycle, the erase timer is frozen, and reads return stored data.
- R10: While an erase is suspended, a program to another sector runs and completes, and the erase stays suspended afterwards. A program aimed at the suspended sector is dropped. Writing 0x30 resumes the erase for its remaining cycles.
- R11: Writes 0xAA@0x15, 0x55@0x0A, 0x20@0x15 enter bypass mode. In bypass mode, 0xA0 followed by (addr,data) programs. Writes 0x90 then 0x00 leave bypass mode.
- R12: A sequence with a wrong address or data value is discarded with no job started. Writes during a running job are ignored, except 0xB0 during an erase.
- R13: rd_data_o holds its value in cycles that follow no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 5 | Write address {bank, sector, word} |
| wr_data_i | input | 8 | Write data or command code |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | 5 | Read address |
| rd_data_o | output | 8 | Array data or status word, one cycle after the read |
| ready_o | output | 1 | Low while a job is running |

## Verification
Assertions check on every cycle that the ready output falls only after a host write, that a suspended erase reports ready, and that the bypass flag changes only on writes. They also check that erase status words carry a zero bit 7 and matching bits 6 and 2, that back-to-back status reads flip bit 6, and that read data holds when there was no read. Only the bench scenarios can show the exact busy windows, the AND-only program result, the erased sector contents, the dropping of malformed or blocked sequences, the program run inside a suspended erase, and a reset aborting a job.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  typedef enum logic [2:0] {OP_NONE, OP_PROG, OP_ERASE, OP_SUSP, OP_PROG_SUSP} op_e;
  typedef enum logic [2:0] {ST_IDLE, ST_UNL1, ST_UNL2, ST_PDATA,
                            ST_ERA1, ST_ERA2, ST_ERA3, ST_BEXIT} step_e;
  localparam logic [7:0] C_UNL_A  = 8'hAA;
  localparam logic [7:0] C_UNL_B  = 8'h55;
  localparam logic [7:0] C_PROG   = 8'hA0;
  localparam logic [7:0] C_ERASE  = 8'h80;
  localparam logic [7:0] C_CONF   = 8'h30;
  localparam logic [7:0] C_BYP    = 8'h20;
  localparam logic [7:0] C_BEXIT  = 8'h90;
  localparam logic [7:0] C_SUSP   = 8'hB0;
endpackage

// File: rtl/fseq_cmd_decode.sv
module fseq_cmd_decode import fseq_pkg::*; #(
  parameter int AW  = 5,
  parameter int SAW = 3,
  parameter int A1  = 'h15,
  parameter int A2  = 'h0A
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [7:0]     data_i,
  input  op_e            op_i,
  input  logic [SAW-1:0] susp_sect_i,
  output logic           prog_go_o,
  output logic           erase_go_o,
  output logic           susp_go_o,
  output logic           resume_go_o,
  output logic           bypass_o
);
  step_e step_q, step_d;
  logic  byp_q, byp_d;
  logic  hit1, hit2;

  assign hit1 = addr_i == AW'(A1);
  assign hit2 = addr_i == AW'(A2);
  assign bypass_o = byp_q;

  always_comb begin
    step_d = step_q;
    byp_d = byp_q;
    prog_go_o = 1'b0;
    erase_go_o = 1'b0;
    susp_go_o = 1'b0;
    resume_go_o = 1'b0;
    if (wr_en_i) begin
      step_d = ST_IDLE;
      if (op_i == OP_ERASE) begin
        susp_go_o = data_i == C_SUSP;
      end else if (op_i == OP_NONE || op_i == OP_SUSP) begin
        case (step_q)
          ST_IDLE:
            if (hit1 && data_i == C_UNL_A) step_d = ST_UNL1;
            else if (byp_q && data_i == C_PROG) step_d = ST_PDATA;
            else if (byp_q && data_i == C_BEXIT) step_d = ST_BEXIT;
            else if (op_i == OP_SUSP && data_i == C_CONF) resume_go_o = 1'b1;
          ST_UNL1: if (hit2 && data_i == C_UNL_B) step_d = ST_UNL2;
          ST_UNL2:
            if (hit1) begin
              if (data_i == C_PROG) step_d = ST_PDATA;
              else if (data_i == C_ERASE && op_i == OP_NONE) step_d = ST_ERA1;
              else if (data_i == C_BYP) byp_d = 1'b1;
            end
          // a program into the sector under a suspended erase is dropped
          ST_PDATA: prog_go_o = !(op_i == OP_SUSP && addr_i[AW-1 -: SAW] == susp_sect_i);
          ST_ERA1: if (hit1 && data_i == C_UNL_A) step_d = ST_ERA2;
          ST_ERA2: if (hit2 && data_i == C_UNL_B) step_d = ST_ERA3;
          ST_ERA3: erase_go_o = data_i == C_CONF;
          ST_BEXIT: if (data_i == 8'h00) byp_d = 1'b0;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= ST_IDLE;
      byp_q <= 1'b0;
    end else begin
      step_q <= step_d;
      byp_q <= byp_d;
    end
  end
endmodule

// File: rtl/fseq_job_timer.sv
module fseq_job_timer import fseq_pkg::*; #(
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic prog_go_i,
  input  logic erase_go_i,
  input  logic susp_go_i,
  input  logic resume_go_i,
  output op_e  op_o,
  output logic prog_done_o,
  output logic erase_done_o
);
  localparam int PCW = $clog2(PROG_CYCLES + 1);
  localparam int ECW = $clog2(ERASE_CYCLES + 1);

  op_e            op_q;
  logic [PCW-1:0] pcnt_q;
  logic [ECW-1:0] ecnt_q;

  assign op_o = op_q;
  assign prog_done_o = (op_q == OP_PROG || op_q == OP_PROG_SUSP) && pcnt_q == '0;
  assign erase_done_o = op_q == OP_ERASE && !susp_go_i && ecnt_q == '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q <= OP_NONE;
      pcnt_q <= '0;
      ecnt_q <= '0;
    end else begin
      case (op_q)
        OP_NONE:
          if (prog_go_i) begin
            op_q <= OP_PROG;
            pcnt_q <= PCW'(PROG_CYCLES - 1);
          end else if (erase_go_i) begin
            op_q <= OP_ERASE;
            ecnt_q <= ECW'(ERASE_CYCLES - 1);
          end
        OP_PROG, OP_PROG_SUSP:
          if (pcnt_q == '0) op_q <= (op_q == OP_PROG) ? OP_NONE : OP_SUSP;
          else pcnt_q <= pcnt_q - 1'b1;
        OP_ERASE:
          if (susp_go_i) op_q <= OP_SUSP;
          else if (ecnt_q == '0) op_q <= OP_NONE;
          else ecnt_q <= ecnt_q - 1'b1;
        OP_SUSP:
          if (resume_go_i) op_q <= OP_ERASE;
          else if (prog_go_i) begin
            op_q <= OP_PROG_SUSP;
            pcnt_q <= PCW'(PROG_CYCLES - 1);
          end
        default: op_q <= OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/fseq_array.sv
module fseq_array import fseq_pkg::*; #(
  parameter int BANKS = 4,
  parameter int SECTS = 2,
  parameter int WORDS = 4,
  parameter int DW    = 8,
  localparam int BW    = $clog2(BANKS),
  localparam int SAW   = BW + $clog2(SECTS),
  localparam int AW    = SAW + $clog2(WORDS),
  localparam int DEPTH = BANKS * SECTS * WORDS
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  op_e            op_i,
  input  logic           busy_i,
  input  logic           prog_go_i,
  input  logic           erase_go_i,
  input  logic           prog_done_i,
  input  logic           erase_done_i,
  input  logic [AW-1:0]  wr_addr_i,
  input  logic [DW-1:0]  wr_data_i,
  input  logic           rd_en_i,
  input  logic [AW-1:0]  rd_addr_i,
  output logic [DW-1:0]  rd_data_o,
  output logic [SAW-1:0] esect_o,
  output logic           rd_hit_o
);
  logic [DEPTH-1:0][DW-1:0] mem;
  logic [AW-1:0]  paddr_q;
  logic [DW-1:0]  pdata_q, status, rdata_q;
  logic [SAW-1:0] esect_q;
  logic [BW-1:0]  busy_bank;
  logic           tog_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    localparam int SEC = g / WORDS;
    logic [DW-1:0] word_q;
    always_ff @(posedge clk_i) begin
      if (erase_done_i && esect_q == SAW'(SEC)) word_q <= '1;
      else if (prog_done_i && paddr_q == AW'(g)) word_q <= word_q & pdata_q;
    end
    assign mem[g] = word_q;
  end

  assign busy_bank = (op_i == OP_ERASE) ? esect_q[SAW-1 -: BW] : paddr_q[AW-1 -: BW];
  assign rd_hit_o = rd_en_i && busy_i && rd_addr_i[AW-1 -: BW] == busy_bank;
  assign esect_o = esect_q;
  assign rd_data_o = rdata_q;

  always_comb begin
    status = '0;
    status[7] = (op_i == OP_ERASE) ? 1'b0 : ~pdata_q[7];
    status[6] = tog_q;
    status[2] = (op_i == OP_ERASE) & tog_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      paddr_q <= '0;
      pdata_q <= '0;
      esect_q <= '0;
      tog_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (prog_go_i) begin
        paddr_q <= wr_addr_i;
        pdata_q <= wr_data_i;
      end
      if (erase_go_i) esect_q <= wr_addr_i[AW-1 -: SAW];
      if (prog_go_i || erase_go_i) tog_q <= 1'b0;
      else if (rd_hit_o) tog_q <= ~tog_q;
      if (rd_en_i) rdata_q <= rd_hit_o ? status : mem[rd_addr_i];
    end
  end
endmodule

// File: rtl/flash_dual_op_seq.sv
module flash_dual_op_seq import fseq_pkg::*; #(
  parameter int BANKS        = 4,
  parameter int SECTS        = 2,
  parameter int WORDS        = 4,
  parameter int DW           = 8,
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 16,
  parameter int UNLOCK_A1    = 'h15,
  parameter int UNLOCK_A2    = 'h0A,
  localparam int SAW = $clog2(BANKS) + $clog2(SECTS),
  localparam int AW  = SAW + $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          ready_o
);
  op_e            op;
  logic           prog_go, erase_go, susp_go, resume_go, bypass;
  logic           prog_done, erase_done, job_go, rd_hit;
  logic [SAW-1:0] esect;

  assign ready_o = !(op == OP_PROG || op == OP_ERASE || op == OP_PROG_SUSP);
  assign job_go = prog_go | erase_go;

  fseq_cmd_decode #(.AW(AW), .SAW(SAW), .A1(UNLOCK_A1), .A2(UNLOCK_A2)) u_dec (
    .clk_i, .rst_ni, .wr_en_i, .addr_i(wr_addr_i), .data_i(wr_data_i[7:0]),
    .op_i(op), .susp_sect_i(esect), .prog_go_o(prog_go), .erase_go_o(erase_go),
    .susp_go_o(susp_go), .resume_go_o(resume_go), .bypass_o(bypass)
  );

  fseq_job_timer #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_tmr (
    .clk_i, .rst_ni, .prog_go_i(prog_go), .erase_go_i(erase_go),
    .susp_go_i(susp_go), .resume_go_i(resume_go), .op_o(op),
    .prog_done_o(prog_done), .erase_done_o(erase_done)
  );

  fseq_array #(.BANKS(BANKS), .SECTS(SECTS), .WORDS(WORDS), .DW(DW)) u_arr (
    .clk_i, .rst_ni, .op_i(op), .busy_i(!ready_o), .prog_go_i(prog_go),
    .erase_go_i(erase_go), .prog_done_i(prog_done), .erase_done_i(erase_done),
    .wr_addr_i, .wr_data_i, .rd_en_i, .rd_addr_i, .rd_data_o,
    .esect_o(esect), .rd_hit_o(rd_hit)
  );
endmodule

// File: rtl/fseq_chk.sv
module fseq_chk import fseq_pkg::*; #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic          rd_en_i,
  input logic [DW-1:0] rd_data_i,
  input logic          ready_i,
  input op_e           op_i,
  input logic          bypass_i,
  input logic          job_go_i,
  input logic          rd_hit_i
);
  logic hit_q, era_q, go_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q <= 1'b0;
      era_q <= 1'b0;
      go_q <= 1'b0;
    end else begin
      hit_q <= rd_hit_i;
      era_q <= rd_hit_i && op_i == OP_ERASE;
      go_q <= job_go_i;
    end
  end

  assert_ready_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_i) |-> $past(wr_en_i));
  assert_susp_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_SUSP |-> ready_i);
  assert_erase_status_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    era_q |-> (rd_data_i[7] == 1'b0 && rd_data_i[6] == rd_data_i[2]));
  assert_toggle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_q && $past(hit_q) && !$past(go_q)) |-> rd_data_i[6] != $past(rd_data_i[6]));
  assert_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_en_i) |-> $stable(rd_data_i));
  assert_bypass_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bypass_i) |-> $past(wr_en_i));
endmodule

bind flash_dual_op_seq fseq_chk #(.DW(DW)) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .rd_data_i(rd_data_o), .ready_i(ready_o),
  .op_i(op), .bypass_i(bypass), .job_go_i(job_go), .rd_hit_i(rd_hit)
);

// File: tb/flash_dual_op_seq_test.sv
module flash_dual_op_seq_test;
  localparam int PC = 8;
  localparam int EC = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       ready;

  int errs = 0, checks = 0;
  bit run = 0, done = 0;
  int m_op = 0, m_pc = 0, m_ec = 0, req = 0;

  always #2 clk = ~clk;

  flash_dual_op_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .ready_o(ready)
  );

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // reference job model: 0 idle, 1 program, 2 erase, 3 suspended, 4 program in suspend
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_op = 0;
      req = 0;
    end else begin
      case (m_op)
        0: if (req == 1) begin m_op = 1; m_pc = PC - 1; end
           else if (req == 2) begin m_op = 2; m_ec = EC - 1; end
        1: if (m_pc == 0) m_op = 0; else m_pc--;
        2: if (req == 3) m_op = 3; else if (m_ec == 0) m_op = 0; else m_ec--;
        3: if (req == 4) m_op = 2;
           else if (req == 1) begin m_op = 4; m_pc = PC - 1; end
        4: if (m_pc == 0) m_op = 3; else m_pc--;
        default: m_op = 0;
      endcase
      req = 0;
    end
  end

  // ready window compared on every cycle (R2, R4, R9, R10, R12)
  always @(negedge clk) begin
    if (run && rst_n) begin
      automatic bit exp = (m_op == 0 || m_op == 3);
      chk(ready == exp, "R2 ready window", int'(ready), int'(exp));
    end
  end

  task automatic wr(input int a, input int d, input int r);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = 8'(d); req = r;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input int exp, input string r);
    rd_en = 1'b1; rd_addr = 5'(a);
    @(negedge clk);
    rd_en = 1'b0;
    chk(rd_data == 8'(exp), r, int'(rd_data), exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_done();
    while (m_op == 1 || m_op == 2 || m_op == 4) @(negedge clk);
  endtask

  task automatic prog_full(input int a, input int d, input int r);
    wr('h15, 'hAA, 0); wr('h0A, 'h55, 0); wr('h15, 'hA0, 0); wr(a, d, r);
  endtask

  task automatic erase_sect(input int a);
    wr('h15, 'hAA, 0); wr('h0A, 'h55, 0); wr('h15, 'h80, 0);
    wr('h15, 'hAA, 0); wr('h0A, 'h55, 0); wr(a, 'h30, 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    chk(ready == 1'b1, "R1 ready in reset", int'(ready), 1);
    #1 rst_n = 1'b1;
    @(negedge clk);
    run = 1;
    chk(ready == 1'b1, "R1 ready after reset", int'(ready), 1);
    chk(rd_data == 8'h00, "R1 read data after reset", int'(rd_data), 0);

    // erase bank1 sector0, poll status
    erase_sect(8);
    idle(3);
    rd(8, 'h00, "R6 erase status");
    rd(9, 'h44, "R7 erase toggles");
    rd(10, 'h00, "R7 erase toggles back");
    wait_done();
    rd(8, 'hFF, "R4 erased word");
    rd(11, 'hFF, "R4 erased word");
    // erase bank0 sector0, read other bank while busy
    erase_sect(0);
    idle(2);
    rd(8, 'hFF, "R5 other bank read");
    wait_done();
    rd(0, 'hFF, "R4 erased word");
    erase_sect(24);
    wait_done();
    rd(27, 'hFF, "R4 erased word");

    // full program with status polling
    prog_full(8, 'h3C, 1);
    rd(0, 'hFF, "R5 other bank read");
    rd(9, 'h80, "R6 program status");
    rd(10, 'hC0, "R7 program toggle");
    wait_done();
    rd(8, 'h3C, "R8 back to array");
    rd(9, 'hFF, "R8 neighbour intact");
    prog_full(8, 'hF0, 1);
    wait_done();
    rd(8, 'h30, "R3 program ands");

    // malformed sequences
    wr('h15, 'hAA, 0); wr('h0A, 'h11, 0); wr('h15, 'hA0, 0); wr(9, 'h00, 0);
    idle(2);
    rd(9, 'hFF, "R12 bad unlock dropped");
    wr('h15, 'hAA, 0); wr('h0A, 'h55, 0); wr('h15, 'h80, 0);
    wr('h15, 'hAA, 0); wr('h0A, 'h55, 0); wr(24, 'h10, 0);
    idle(2);
    rd(24, 'hFF, "R12 bad confirm dropped");

    // unlock bypass
    wr('h15, 'hAA, 0); wr('h0A, 'h55, 0); wr('h15, 'h20, 0);
    wr(0, 'hA0, 0); wr(9, 'h5A, 1);
    wait_done();
    rd(9, 'h5A, "R11 bypass program");
    wr(0, 'hA0, 0); wr(10, 'h0F, 1);
    wait_done();
    rd(10, 'h0F, "R11 second bypass program");
    wr(0, 'h90, 0); wr(0, 'h00, 0);
    wr(0, 'hA0, 0); wr(11, 'h00, 0);
    idle(2);
    rd(11, 'hFF, "R11 bypass left");

    // suspend / resume
    prog_full(24, 'h00, 1);
    wait_done();
    erase_sect(24);
    idle(2);
    wr('h15, 'hAA, 0); wr('h0A, 'h55, 0); wr('h15, 'hA0, 0); wr(2, 'h00, 0);
    wr(0, 'hB0, 3);
    idle(1);
    chk(ready == 1'b1, "R9 ready while suspended", int'(ready), 1);
    rd(24, 'h00, "R9 data read in suspend");
    rd(25, 'hFF, "R9 data read in suspend");
    prog_full(1, 'h11, 1);
    idle(1);
    rd(2, 'h80, "R10 program status in suspend");
    wait_done();
    rd(1, 'h11, "R10 program in suspend");
    chk(ready == 1'b1, "R10 still suspended", int'(ready), 1);
    wr('h15, 'hAA, 0); wr('h0A, 'h55, 0); wr('h15, 'hA0, 0); wr(25, 'h00, 0);
    idle(1);
    rd(25, 'hFF, "R10 blocked sector program dropped");
    wr(0, 'h30, 4);
    chk(ready == 1'b0, "R10 resumed busy", int'(ready), 0);
    wait_done();
    rd(24, 'hFF, "R10 erase completed");
    rd(2, 'hFF, "R12 writes ignored during erase");
    rd(1, 'h11, "R4 other sector untouched");

    // reset during a job
    prog_full(3, 'h00, 1);
    idle(3);
    #1 rst_n = 1'b0;
    @(negedge clk);
    chk(ready == 1'b1, "R1 reset aborts job", int'(ready), 1);
    #1 rst_n = 1'b1;
    @(negedge clk);
    rd(3, 'hFF, "R1 aborted word unchanged");

    rd(1, 'h11, "R5 plain read");
    idle(3);
    chk(rd_data == 8'h11, "R13 read data held", int'(rd_data), 'h11);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule